// File: doc/BRIEF.md
# Dual-Width Host Bus Slave Port

This block is the processor-facing slave port of a display controller. A static strap sets it to serve either an 8-bit or a 16-bit host. The host reaches two spaces through two active-low selects. One select opens a byte-wide register file, addressed by the low eight address bits. The other opens the display memory, which is organised as 16-bit words with two byte enables. The port synchronises the host's selects and strobes into its own clock. It then issues one single-cycle request per host strobe, either to a synchronous SRAM-style memory port or to a register-file port, and keeps the read result on a held output bus.

Byte lanes are steered according to the host width. A 16-bit host addresses words through address bits 14..1. Address bit 0 and an active-low high-lane enable pick the lanes. A second strap can cross the two byte lanes between host and memory. A display-fetch engine outside the block steals memory cycles, and its activity arrives as a busy input. A host memory access that meets a busy fetch is held, and an active-low wait output stretches the host cycle until the access has really been performed.

Top module: `dual_width_host_port`

## Requirements
- R1: `wide_mode` low selects 8-bit host operation and high selects 16-bit host operation. After reset `wait_n` is high, `mem_req`, `reg_we` and `reg_re` are low, and `host_dout` is zero.
- R2: In 8-bit mode the memory word is `host_addr[14:1]`. `host_addr[0]`=0 selects memory byte 0 (`mem_be`=01) and 1 selects byte 1 (`mem_be`=10). Write data is `host_din[7:0]` on both lanes. A read returns the chosen byte on `host_dout[7:0]` with `host_dout[15:8]`=0. `hwr_n` and `bhe_n` have no effect in this mode.
- R3: In 16-bit mode the memory word is `host_addr[14:1]`. The host lanes are chosen as follows: {A0=0,`bhe_n`=0} selects both lanes, {0,1} the low lane `host_din[7:0]`, {1,0} the high lane `host_din[15:8]`, and {1,1} no lane. Lanes that are not chosen read back as zero. An access with no lane produces no memory request.
- R4: In 16-bit mode a write stores the host low lane only while `lwr_n` is low and the host high lane only while `hwr_n` is low, in both cases within the lanes chosen by R3.
- R5: In 16-bit mode, with `swap_lanes`=0 the host low lane maps to memory byte 0 (`mem_wdata[7:0]`, `mem_be[0]`). With `swap_lanes`=1 the two lanes are crossed for writes, byte enables and reads.
- R6: With `io_sel_n` low, an access goes to register `host_addr[7:0]` with data on `host_din[7:0]` in either mode. Only `lwr_n` writes a register. A read returns {8'h00, register}.
- R7: When both selects are low, no request of any kind is issued.
- R8: `wait_n` is low while `mem_sel_n` and a strobe are low and the memory access has not yet completed, provided the fetch is busy or the access has been held by one. A register access never lowers `wait_n`.
- R9: A held memory access is issued in the first cycle in which `fetch_busy` is low. `wait_n` rises at the clock edge that completes it: the issuing edge for a write, or the following edge for a read, at which `host_dout` becomes valid.
- R10: `steal_act` is high exactly while `fetch_busy` is high.
- R11: A strobe held low for many cycles yields exactly one request. A further access needs the strobes released first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-side clock |
| rst_n | input | 1 | Active-low reset |
| wide_mode | input | 1 | Strap: 0 = 8-bit host, 1 = 16-bit host |
| swap_lanes | input | 1 | Strap: cross host/memory byte lanes (16-bit mode) |
| host_addr | input | 15 | Host address |
| host_din | input | 16 | Host write data |
| host_dout | output | 16 | Held read data toward the host |
| io_sel_n | input | 1 | Register-space select, active low |
| mem_sel_n | input | 1 | Memory-space select, active low |
| rd_n | input | 1 | Read strobe, active low |
| lwr_n | input | 1 | Low-lane write strobe, active low |
| hwr_n | input | 1 | High-lane write strobe, active low |
| bhe_n | input | 1 | High-lane enable, active low |
| wait_n | output | 1 | Host wait, active low |
| steal_act | output | 1 | Fetch cycle-steal in progress |
| fetch_busy | input | 1 | Display fetch owns memory this cycle |
| mem_req | output | 1 | Memory request pulse |
| mem_we | output | 1 | Memory write when high |
| mem_addr | output | 14 | Memory word address |
| mem_be | output | 2 | Memory byte enables |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after request |
| reg_we | output | 1 | Register write pulse |
| reg_re | output | 1 | Register read pulse |
| reg_addr | output | 8 | Register index |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, same cycle |

## Verification
A host memory access and a fetch cycle-steal can fall in the same cycle. In that case the access must be held while the wait output stays low, and it must run exactly once when the fetch lets go. The bench provokes this by raising the busy input before and during the host strobes, for both a write and a read. It then drops busy and judges the cycle in which the memory model changes, the cycle in which wait rises, and the data returned. Register accesses made under busy are checked to leave wait high.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_RDWAIT = 2'd1,
      ST_DONE   = 2'd2
   } hbi_state_e;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q[s] <= '1;
            else        chain_q[s] <= d_in;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q[s] <= '1;
            else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/hbi_lanes.sv
module hbi_lanes #(
   parameter int LANE_W = 8,
   localparam int DATA_W = 2 * LANE_W
) (
   input  logic              wide,
   input  logic              swap,
   input  logic              a0,
   input  logic              bhe_n,
   input  logic              s_lwr,
   input  logic              s_hwr,
   input  logic              is_rd,
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-1:0] rdata,
   output logic [1:0]        be,
   output logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rfmt
);
   logic [1:0]        hsel;
   logic [1:0]        hmask;
   logic [DATA_W-1:0] din_x;
   logic [DATA_W-1:0] rd_x;
   logic [DATA_W-1:0] rd_wide;

   assign hsel  = {~bhe_n, ~a0};
   assign hmask = is_rd ? hsel : (hsel & {s_hwr, s_lwr});
   assign din_x = swap ? {din[LANE_W-1:0], din[DATA_W-1:LANE_W]} : din;
   assign rd_x  = swap ? {rdata[LANE_W-1:0], rdata[DATA_W-1:LANE_W]} : rdata;

   for (genvar l = 0; l < 2; l++) begin : g_lane
      assign rd_wide[l*LANE_W +: LANE_W] = hsel[l] ? rd_x[l*LANE_W +: LANE_W] : '0;
   end

   always_comb begin
      if (wide) begin
         be    = swap ? {hmask[0], hmask[1]} : hmask;
         wdata = din_x;
         rfmt  = rd_wide;
      end else begin
         be    = a0 ? 2'b10 : 2'b01;
         wdata = {din[LANE_W-1:0], din[LANE_W-1:0]};
         rfmt  = {{LANE_W{1'b0}}, (a0 ? rdata[DATA_W-1:LANE_W] : rdata[LANE_W-1:0])};
      end
   end
endmodule

// File: rtl/hbi_ctl.sv
module hbi_ctl
   import hbi_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wide,
   input  logic fetch_busy,
   input  logic raw_ov,
   input  logic s_io,
   input  logic s_mem,
   input  logic s_rd,
   input  logic s_lwr,
   input  logic s_hwr,
   input  logic lane_none,
   output logic mem_req,
   output logic mem_we,
   output logic reg_we,
   output logic reg_re,
   output logic cap_reg,
   output logic cap_mem,
   output logic wait_n
);
   hbi_state_e state_q, state_d;
   logic       stalled_q, stalled_d;
   logic       sel_io, sel_mem, io_go, mem_go, bus_act;

   assign sel_io  = s_io & ~s_mem;
   assign sel_mem = s_mem & ~s_io;
   assign io_go   = sel_io & (s_rd | s_lwr);
   assign mem_go  = sel_mem & (s_rd | s_lwr | (wide & s_hwr));
   assign bus_act = (s_io | s_mem) & (s_rd | s_lwr | s_hwr);

   always_comb begin
      state_d = state_q;
      mem_req = 1'b0;
      mem_we  = 1'b0;
      reg_we  = 1'b0;
      reg_re  = 1'b0;
      cap_reg = 1'b0;
      cap_mem = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (io_go) begin
               reg_re  = s_rd;
               reg_we  = ~s_rd;
               cap_reg = s_rd;
               state_d = ST_DONE;
            end else if (mem_go && !fetch_busy) begin
               mem_req = ~lane_none;
               mem_we  = ~lane_none & ~s_rd;
               state_d = (s_rd && !lane_none) ? ST_RDWAIT : ST_DONE;
            end
         end
         ST_RDWAIT: begin
            cap_mem = 1'b1;
            state_d = ST_DONE;
         end
         ST_DONE: begin
            if (!bus_act) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      if (state_d == ST_DONE || (state_q == ST_IDLE && !mem_go))
         stalled_d = 1'b0;
      else if (state_q == ST_IDLE && mem_go && fetch_busy)
         stalled_d = 1'b1;
      else
         stalled_d = stalled_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         stalled_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         stalled_q <= stalled_d;
      end
   end

   assign wait_n = ~(raw_ov & (state_q != ST_DONE) & (fetch_busy | stalled_q));
endmodule

// File: rtl/dual_width_host_port.sv
module dual_width_host_port #(
   parameter int HOST_AW     = 15,
   parameter int LANE_W      = 8,
   parameter int REG_AW      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int DATA_W  = 2 * LANE_W,
   localparam int WORD_AW = HOST_AW - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wide_mode,
   input  logic               swap_lanes,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [DATA_W-1:0]  host_din,
   output logic [DATA_W-1:0]  host_dout,
   input  logic               io_sel_n,
   input  logic               mem_sel_n,
   input  logic               rd_n,
   input  logic               lwr_n,
   input  logic               hwr_n,
   input  logic               bhe_n,
   output logic               wait_n,
   output logic               steal_act,
   input  logic               fetch_busy,
   output logic               mem_req,
   output logic               mem_we,
   output logic [WORD_AW-1:0] mem_addr,
   output logic [1:0]         mem_be,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               reg_we,
   output logic               reg_re,
   output logic [REG_AW-1:0]  reg_addr,
   output logic [LANE_W-1:0]  reg_wdata,
   input  logic [LANE_W-1:0]  reg_rdata
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (REG_AW > HOST_AW) begin : g_bad_reg
      $error("REG_AW must not exceed HOST_AW");
   end
   if (LANE_W < 1) begin : g_bad_lane
      $error("LANE_W must be positive");
   end

   logic [4:0]        raw_n, syn_n;
   logic              s_io, s_mem, s_rd, s_lwr, s_hwr;
   logic              raw_ov;
   logic              cap_reg, cap_mem;
   logic [DATA_W-1:0] rfmt;
   logic [DATA_W-1:0] dout_q;

   assign raw_n = {io_sel_n, mem_sel_n, rd_n, lwr_n, hwr_n};

   hbi_sync #(.WIDTH(5), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (raw_n),
      .d_out (syn_n)
   );

   assign {s_io, s_mem, s_rd, s_lwr, s_hwr} = ~syn_n;

   hbi_lanes #(.LANE_W(LANE_W)) lanes_i (
      .wide  (wide_mode),
      .swap  (swap_lanes),
      .a0    (host_addr[0]),
      .bhe_n (bhe_n),
      .s_lwr (s_lwr),
      .s_hwr (s_hwr),
      .is_rd (s_rd),
      .din   (host_din),
      .rdata (mem_rdata),
      .be    (mem_be),
      .wdata (mem_wdata),
      .rfmt  (rfmt)
   );

   assign raw_ov = ~mem_sel_n & io_sel_n & (~rd_n | ~lwr_n | (wide_mode & ~hwr_n));

   hbi_ctl ctl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wide       (wide_mode),
      .fetch_busy (fetch_busy),
      .raw_ov     (raw_ov),
      .s_io       (s_io),
      .s_mem      (s_mem),
      .s_rd       (s_rd),
      .s_lwr      (s_lwr),
      .s_hwr      (s_hwr),
      .lane_none  (mem_be == 2'b00),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .reg_we     (reg_we),
      .reg_re     (reg_re),
      .cap_reg    (cap_reg),
      .cap_mem    (cap_mem),
      .wait_n     (wait_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dout_q <= '0;
      else if (cap_reg) dout_q <= {{LANE_W{1'b0}}, reg_rdata};
      else if (cap_mem) dout_q <= rfmt;
   end

   assign host_dout = dout_q;
   assign steal_act = fetch_busy;
   assign mem_addr  = host_addr[HOST_AW-1:1];
   assign reg_addr  = host_addr[REG_AW-1:0];
   assign reg_wdata = host_din[LANE_W-1:0];
endmodule

// File: rtl/dual_width_host_port_chk.sv
module dual_width_host_port_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wide_mode,
   input logic       mem_sel_n,
   input logic       io_sel_n,
   input logic       wait_n,
   input logic       fetch_busy,
   input logic       mem_req,
   input logic [1:0] mem_be,
   input logic       reg_we,
   input logic       reg_re
);
   // R11
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   // R7
   port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_req, reg_we, reg_re}));

   // R2
   narrow_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !wide_mode) |-> ($countones(mem_be) == 1));

   // R3
   no_empty_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_be != 2'b00));

   // R8
   wait_mem_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wait_n |-> (!mem_sel_n && io_sel_n));

   // R9
   req_free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !fetch_busy);
endmodule

bind dual_width_host_port dual_width_host_port_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .wide_mode  (wide_mode),
   .mem_sel_n  (mem_sel_n),
   .io_sel_n   (io_sel_n),
   .wait_n     (wait_n),
   .fetch_busy (fetch_busy),
   .mem_req    (mem_req),
   .mem_be     (mem_be),
   .reg_we     (reg_we),
   .reg_re     (reg_re)
);

// File: tb/dual_width_host_port_tb.sv
`timescale 1ns/1ps
module dual_width_host_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide_mode = 1'b1, swap_lanes = 1'b0;
   logic [14:0] host_addr = '0;
   logic [15:0] host_din = '0;
   logic [15:0] host_dout;
   logic        io_sel_n = 1'b1, mem_sel_n = 1'b1, rd_n = 1'b1, lwr_n = 1'b1, hwr_n = 1'b1, bhe_n = 1'b1;
   logic        wait_n, steal_act;
   logic        fetch_busy = 1'b0;
   logic        mem_req, mem_we;
   logic [13:0] mem_addr;
   logic [1:0]  mem_be;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        reg_we, reg_re;
   logic [7:0]  reg_addr, reg_wdata, reg_rdata;

   logic [15:0] mem_m [16];
   logic [7:0]  regs_m [256];
   int          req_cnt = 0;
   int          checks = 0, errors = 0;
   bit          finished = 0;

   always #4 clk = ~clk;

   dual_width_host_port dut_i (
      .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .swap_lanes(swap_lanes),
      .host_addr(host_addr), .host_din(host_din), .host_dout(host_dout),
      .io_sel_n(io_sel_n), .mem_sel_n(mem_sel_n), .rd_n(rd_n), .lwr_n(lwr_n),
      .hwr_n(hwr_n), .bhe_n(bhe_n), .wait_n(wait_n), .steal_act(steal_act),
      .fetch_busy(fetch_busy), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .reg_we(reg_we), .reg_re(reg_re),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   assign reg_rdata = regs_m[reg_addr];

   always @(posedge clk) begin
      if (mem_req) begin
         req_cnt <= req_cnt + 1;
         if (mem_we) begin
            if (mem_be[0]) mem_m[mem_addr[3:0]][7:0]  <= mem_wdata[7:0];
            if (mem_be[1]) mem_m[mem_addr[3:0]][15:8] <= mem_wdata[15:8];
         end else begin
            mem_rdata <= mem_m[mem_addr[3:0]];
         end
      end
      if (reg_we) regs_m[reg_addr] <= reg_wdata;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input bit io, input bit mm, input bit rd, input bit lw, input bit hw,
                        input logic [14:0] a, input logic bh, input logic [15:0] d);
      @(negedge clk);
      host_addr = a; bhe_n = bh; host_din = d;
      io_sel_n = ~io; mem_sel_n = ~mm; rd_n = ~rd; lwr_n = ~lw; hwr_n = ~hw;
   endtask

   task automatic release_bus();
      @(negedge clk);
      io_sel_n = 1; mem_sel_n = 1; rd_n = 1; lwr_n = 1; hwr_n = 1;
      repeat (4) @(negedge clk);
   endtask

   task automatic op(input bit io, input bit mm, input bit rd, input bit lw, input bit hw,
                     input logic [14:0] a, input logic bh, input logic [15:0] d);
      drive(io, mm, rd, lw, hw, a, bh, d);
      repeat (6) @(negedge clk);
      release_bus();
   endtask

   function automatic logic [15:0] bswap(input logic [15:0] v);
      return {v[7:0], v[15:8]};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] d, ex, hw_v;
      logic [1:0]  h, be;
      int          c0;
      for (int i = 0; i < 16; i++) mem_m[i] = '0;
      for (int i = 0; i < 256; i++) regs_m[i] = 8'(i);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 wait", 32'(wait_n), 1);
      chk("R1 req", 32'({mem_req, reg_we, reg_re}), 0);
      chk("R1 dout", 32'(host_dout), 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R3 R5 16-bit sweep over swap, A0, bhe_n
      wide_mode = 1;
      for (int sw = 0; sw < 2; sw++) begin
         for (int a0 = 0; a0 < 2; a0++) begin
            for (int bh = 0; bh < 2; bh++) begin
               swap_lanes = sw[0];
               mem_m[3] = 16'hA1B2;
               d = 16'hC3D4 + 16'(sw * 4 + a0 * 2 + bh) * 16'h0101;
               c0 = req_cnt;
               op(0, 1, 0, 1, 1, 15'(6 + a0), bh[0], d);
               h  = {~bh[0], ~a0[0]};
               be = sw[0] ? {h[0], h[1]} : h;
               ex = sw[0] ? bswap(d) : d;
               ex = {be[1] ? ex[15:8] : 8'hA1, be[0] ? ex[7:0] : 8'hB2};
               chk("R5 R3 write", 32'(mem_m[3]), 32'(ex));
               chk("R3 req count", 32'(req_cnt - c0), 32'(be != 0));
               op(0, 1, 1, 0, 0, 15'(6 + a0), bh[0], 16'h0);
               hw_v = sw[0] ? bswap(ex) : ex;
               hw_v = {h[1] ? hw_v[15:8] : 8'h00, h[0] ? hw_v[7:0] : 8'h00};
               if (h != 0) chk("R3 R5 read", 32'(host_dout), 32'(hw_v));
            end
         end
      end

      // R4 single strobes in 16-bit mode, no swap
      swap_lanes = 0;
      mem_m[4] = 16'h0000;
      op(0, 1, 0, 1, 0, 15'd8, 1'b0, 16'h1234);
      chk("R4 low only", 32'(mem_m[4]), 32'h0034);
      op(0, 1, 0, 0, 1, 15'd8, 1'b0, 16'h5678);
      chk("R4 high only", 32'(mem_m[4]), 32'h5634);

      // R2 8-bit mode: hwr_n, bhe_n and swap ignored
      wide_mode = 0;
      swap_lanes = 1;
      for (int a0 = 0; a0 < 2; a0++) begin
         mem_m[5] = 16'h1122;
         op(0, 1, 0, 1, 1, 15'(10 + a0), 1'b0, 16'hEE77);
         ex = a0 ? 16'h7722 : 16'h1177;
         chk("R2 byte write", 32'(mem_m[5]), 32'(ex));
         op(0, 1, 1, 0, 0, 15'(10 + a0), 1'b0, 16'h0);
         chk("R2 byte read", 32'(host_dout), 32'h0077);
      end
      c0 = req_cnt;
      op(0, 1, 0, 0, 1, 15'd10, 1'b0, 16'hFFFF);
      chk("R2 hwr ignored cnt", 32'(req_cnt - c0), 0);
      chk("R2 hwr ignored mem", 32'(mem_m[5]), 32'h7722);

      // R6 register space
      op(1, 0, 0, 1, 0, 15'h015A, 1'b0, 16'hBEEF);
      chk("R6 reg write 8b", 32'(regs_m[8'h5A]), 32'hEF);
      wide_mode = 1;
      swap_lanes = 0;
      op(1, 0, 0, 1, 0, 15'h005B, 1'b0, 16'hCAFE);
      chk("R6 reg write 16b", 32'(regs_m[8'h5B]), 32'hFE);
      op(1, 0, 0, 0, 1, 15'h005C, 1'b0, 16'hCAFE);
      chk("R6 hwr no reg write", 32'(regs_m[8'h5C]), 32'h5C);
      op(1, 0, 1, 0, 0, 15'h005A, 1'b0, 16'h0);
      chk("R6 reg read", 32'(host_dout), 32'h00EF);

      // R7 both selects
      c0 = req_cnt;
      op(1, 1, 0, 1, 1, 15'h0010, 1'b0, 16'h9999);
      chk("R7 no reg write", 32'(regs_m[8'h10]), 32'h10);
      chk("R7 no mem req", 32'(req_cnt - c0), 0);

      // R11 long strobe gives one request
      c0 = req_cnt;
      drive(0, 1, 0, 1, 1, 15'd2, 1'b0, 16'h4242);
      repeat (30) @(negedge clk);
      release_bus();
      chk("R11 single req", 32'(req_cnt - c0), 1);

      // R10 R8 R9 collision with fetch: write
      @(negedge clk);
      fetch_busy = 1;
      #1 chk("R10 steal on", 32'(steal_act), 1);
      mem_m[6] = 16'h0;
      c0 = req_cnt;
      drive(0, 1, 0, 1, 1, 15'd12, 1'b0, 16'h6161);
      #1 chk("R8 wait falls", 32'(wait_n), 0);
      repeat (5) @(negedge clk);
      chk("R8 wait held", 32'(wait_n), 0);
      chk("R9 no req while busy", 32'(req_cnt - c0), 0);
      fetch_busy = 0;
      #1 chk("R9 wait low until edge", 32'(wait_n), 0);
      chk("R10 steal off", 32'(steal_act), 0);
      @(posedge clk); #1;
      chk("R9 write wait rises", 32'(wait_n), 1);
      chk("R9 write done", 32'(mem_m[6]), 32'h6161);
      release_bus();

      // R8 R9 collision: read
      fetch_busy = 1;
      drive(0, 1, 1, 0, 0, 15'd12, 1'b0, 16'h0);
      repeat (5) @(negedge clk);
      chk("R8 read wait", 32'(wait_n), 0);
      fetch_busy = 0;
      @(posedge clk); #1;
      chk("R9 read wait still low", 32'(wait_n), 0);
      @(posedge clk); #1;
      chk("R9 read wait rises", 32'(wait_n), 1);
      chk("R9 read data", 32'(host_dout), 32'h6161);
      release_bus();

      // R8 register access under busy never waits
      fetch_busy = 1;
      drive(1, 0, 1, 0, 0, 15'h005B, 1'b0, 16'h0);
      #1 chk("R8 reg no wait", 32'(wait_n), 1);
      repeat (6) @(negedge clk);
      chk("R8 reg read under busy", 32'(host_dout), 32'h00FE);
      release_bus();
      fetch_busy = 0;

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule